// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block sits between a memory-mapped flash window and a byte-wide SPI shifter. Each bus access of one, two or four bytes is expanded into a complete single-lane flash transaction on the chip select that the access targets. The controller selects the device and sends an opcode. It then sends the address, most significant byte first, followed by any dummy bytes. Next it moves the data bytes, lowest byte first, and finally deselects the device. Each chip select carries a packed 32-bit control word. That word gives the access mode, the opcode, the dummy count and a software-driven chip-select level.

Four modes are supported. A plain read always uses opcode 0x03 and never sends dummies. A fast read takes its opcode and dummy count from the control word. A write mode handles programming. In pass-through mode the bus moves raw data bytes only, and the chip-select line simply follows a bit of the control word, so software can build arbitrary commands. The block rejects an access that its configuration forbids: a write to a device without write permission, a write in either read mode, or a read in write mode. A rejected access is completed at once with an error and causes no SPI traffic.

Top module: `spi_flash_seq`

## Requirements
- R1: The mode is control bits [1:0] (0 read, 1 fast read, 2 write, 3 pass-through); in read mode the opcode sent is 0x03 whatever control bits [23:16] hold.
- R2: In fast-read and write modes the opcode is control bits [23:16]; an opcode of 0x00 there still runs the sequence but completes with `bus_err` high.
- R3: In fast-read mode the number of dummy bytes is {bit 14, bits [7:6]} times 8, halved when control bit 28 is set; no other mode sends dummy bytes.
- R4: Every dummy byte sent equals `dummy_byte`.
- R5: After the opcode the address goes out most significant byte first, as bits [31:0] (four bytes) when `cs_addr4` for that chip select is 1, else bits [23:0] (three bytes).
- R6: In modes 0 to 2 the selected `cs_n` is low from the cycle after the request is accepted until the last byte completes, and is high in the cycle `bus_ready` is asserted and while idle.
- R7: Data bytes are sent least significant first; a read sends 0x00 for each data byte and places the i-th received byte at `bus_rdata[8*i+7:8*i]`.
- R8: In pass-through mode only the data bytes are transferred, and `cs_n` of that chip select equals control bit 2 at all times.
- R9: A write to a chip select whose `cs_wr_en` bit is 0 sends nothing and completes with `bus_err` high.
- R10: A write in read or fast-read mode, or a read in write mode, sends nothing and completes with `bus_err` high in the cycle after the request.
- R11: `bus_size` 0 moves one byte, 1 moves two, and 2 or 3 move four.
- R12: One byte is in flight at a time: `sh_start` is a single-cycle pulse and the next one follows only after `sh_done`. `bus_ready` is a single-cycle pulse. A `bus_req` that arrives while a transaction is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, taken only while idle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_sel | input | CSW | Target chip select |
| bus_addr | input | 32 | Flash byte address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_ready | output | 1 | Completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_err | output | 1 | Error flag, valid with `bus_ready` |
| cs_ctrl | input | 32*NCS | Packed control words, chip select i in bits [32*i+31:32*i] |
| cs_wr_en | input | NCS | Write permission per chip select |
| cs_addr4 | input | NCS | Four-byte addressing per chip select |
| dummy_byte | input | 8 | Value sent for each dummy byte |
| sh_start | output | 1 | Start one byte exchange on the shifter |
| sh_txd | output | 8 | Byte to transmit |
| sh_done | input | 1 | Shifter finished the byte exchange |
| sh_rxd | input | 8 | Byte received, valid with `sh_done` |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The bench builds the block with its default of two chip selects. One chip select is set to three-byte addressing and the other to four-byte addressing, so both address lengths appear. This also lets a pass-through device hold its select low while the other device runs full sequences, which shows that the hold-over of one select does not leak into the other's sequencing. The replying shifter model waits three cycles per byte. The longest dummy run, forty bytes, therefore spans well over a hundred cycles, which leaves room to inject a stray request into the middle of a running transaction.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int NCS = 2,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [CSW-1:0]    bus_sel,
  input  logic [31:0]       bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [32*NCS-1:0] cs_ctrl,
  input  logic [NCS-1:0]    cs_wr_en,
  input  logic [NCS-1:0]    cs_addr4,
  input  logic [7:0]        dummy_byte,
  output logic              sh_start,
  output logic [7:0]        sh_txd,
  input  logic              sh_done,
  input  logic [7:0]        sh_rxd,
  output logic [NCS-1:0]    cs_n
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DONE} st_t;
  localparam logic [1:0] M_READ = 2'd0, M_FAST = 2'd1, M_WRITE = 2'd2, M_PASS = 2'd3;

  st_t st;

  wire [31:0] rq_ctl  = cs_ctrl[32*bus_sel +: 32];
  wire [1:0]  rq_mode = rq_ctl[1:0];
  wire [7:0]  rq_op   = (rq_mode == M_READ) ? 8'h03 : rq_ctl[23:16];
  wire [6:0]  rq_d8   = {1'b0, rq_ctl[14], rq_ctl[7:6], 3'b000};
  wire [6:0]  rq_dum  = (rq_mode != M_FAST) ? 7'd0 : (rq_ctl[28] ? (rq_d8 >> 1) : rq_d8);
  wire [6:0]  rq_hdr  = (rq_mode == M_PASS) ? 7'd0 : (cs_addr4[bus_sel] ? 7'd5 : 7'd4);
  wire [6:0]  rq_nb   = (bus_size == 2'd0) ? 7'd1 : (bus_size == 2'd1) ? 7'd2 : 7'd4;
  wire        rq_rej  = bus_we ? (!cs_wr_en[bus_sel] || !rq_mode[1]) : (rq_mode == M_WRITE);
  wire        rq_zero = (rq_mode == M_FAST || rq_mode == M_WRITE) && (rq_op == 8'h00);

  logic [1:0]     mode_q;
  logic [7:0]     op_q;
  logic [31:0]    addr_q, wdata_q, rdata_q;
  logic           we_q, err_q, rej_q;
  logic [CSW-1:0] sel_q;
  logic [6:0]     hdr_q, dum_q, nb_q, idx_q;

  wire [6:0]  body  = hdr_q + dum_q;
  wire [6:0]  total = body + nb_q;
  wire        last  = (idx_q == total - 7'd1);
  wire [6:0]  apos  = hdr_q - 7'd1 - idx_q;
  wire [6:0]  k     = idx_q - body;
  wire [31:0] a_sh  = addr_q >> {apos[1:0], 3'b000};
  wire [31:0] w_sh  = wdata_q >> {k[1:0], 3'b000};
  wire        busy  = (st == S_SEND) || (st == S_WAIT);

  always_comb begin
    if (hdr_q != 7'd0 && idx_q == 7'd0) sh_txd = op_q;
    else if (idx_q < hdr_q)             sh_txd = a_sh[7:0];
    else if (idx_q < body)              sh_txd = dummy_byte;
    else if (we_q)                      sh_txd = w_sh[7:0];
    else                                sh_txd = 8'h00;
  end

  assign sh_start  = (st == S_SEND);
  assign bus_ready = (st == S_DONE);
  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    wire pass_i = (cs_ctrl[32*i+1 -: 2] == M_PASS);
    assign cs_n[i] = pass_i ? cs_ctrl[32*i+2]
                            : !(busy && sel_q == CSW'(i) && mode_q != M_PASS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= M_READ; op_q <= '0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
      we_q <= 1'b0; err_q <= 1'b0; rej_q <= 1'b0; sel_q <= '0;
      hdr_q <= '0; dum_q <= '0; nb_q <= '0; idx_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (bus_req) begin
          mode_q  <= rq_mode;
          op_q    <= rq_op;
          addr_q  <= bus_addr;
          wdata_q <= bus_wdata;
          we_q    <= bus_we;
          sel_q   <= bus_sel;
          hdr_q   <= rq_hdr;
          dum_q   <= rq_dum;
          nb_q    <= rq_nb;
          idx_q   <= '0;
          rdata_q <= '0;
          err_q   <= rq_rej || rq_zero;
          rej_q   <= rq_rej;
          st      <= rq_rej ? S_DONE : S_SEND;
        end
        S_SEND: st <= S_WAIT;
        S_WAIT: if (sh_done) begin
          if (!we_q && idx_q >= body) rdata_q[{k[1:0], 3'b000} +: 8] <= sh_rxd;
          if (last) st <= S_DONE;
          else begin
            idx_q <= idx_q + 7'd1;
            st    <= S_SEND;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |=> !sh_start);
  assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  assert_cs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_start && mode_q != M_PASS) |-> !cs_n[sel_q]);
  assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && mode_q != M_PASS && cs_ctrl[32*sel_q +: 2] != M_PASS) |-> cs_n[sel_q]);
  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && rej_q) |-> ($past(st) == S_IDLE && bus_err));

endmodule

// File: tb/tb_spi_flash_seq.sv
module tb_spi_flash_seq;
  localparam int TCK = 10;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [0:0] bus_sel = '0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [1:0] bus_size = '0;
  logic bus_ready, bus_err;
  logic [31:0] bus_rdata;
  logic [31:0] ctl [2];
  logic [1:0] wr_en = '0, addr4 = '0;
  logic [7:0] dummy_byte = '0;
  logic sh_start, sh_done = 1'b0;
  logic [7:0] sh_txd, sh_rxd = '0;
  logic [1:0] cs_n;

  always #(TCK/2) clk = ~clk;

  spi_flash_seq #(.NCS(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cs_ctrl({ctl[1], ctl[0]}), .cs_wr_en(wr_en), .cs_addr4(addr4),
    .dummy_byte(dummy_byte), .sh_start(sh_start), .sh_txd(sh_txd),
    .sh_done(sh_done), .sh_rxd(sh_rxd), .cs_n(cs_n));

  int n_cmp = 0, n_bad = 0;
  bit active = 1'b0;
  int cur_sel = 0;
  string cur_tag = "R6";
  byte unsigned exp_tx[$];
  byte unsigned rx_log[$];
  byte unsigned rxgen = 8'h5c;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input logic [1:0] mode, input logic [7:0] op,
      input bit dh, input logic [1:0] dl, input bit dual, input bit inact);
    logic [31:0] c = '0;
    c[1:0] = mode; c[2] = inact; c[7:6] = dl; c[14] = dh; c[23:16] = op; c[28] = dual;
    return c;
  endfunction

  function automatic bit exp_cs(input int i);
    if (ctl[i][1:0] == 2'd3) return ctl[i][2];
    if (active && cur_sel == i && !bus_ready) return 1'b0;
    return 1'b1;
  endfunction

  // shifter model: answers each byte after LAT cycles
  initial begin
    forever begin
      @(negedge clk);
      sh_done = 1'b0;
      if (rst_n && sh_start) begin
        byte unsigned b;
        b = rxgen;
        rxgen = rxgen * 8'd5 + 8'h3b;
        repeat (LAT - 1) @(negedge clk);
        sh_rxd = b;
        sh_done = 1'b1;
        rx_log.push_back(b);
      end
    end
  end

  // per-clock comparison against the behavioural expectation
  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk);
      #(TCK/4);
      if (sh_start) begin
        if (exp_tx.size() == 0) chk(1'b0, cur_tag, "unexpected byte", {24'h0, sh_txd}, 32'h0);
        else begin
          byte unsigned e;
          e = exp_tx.pop_front();
          chk(sh_txd == e, cur_tag, "tx byte", {24'h0, sh_txd}, {24'h0, e});
        end
      end
      for (int i = 0; i < 2; i++)
        chk(cs_n[i] == exp_cs(i), "R6/R8", "cs_n", {31'h0, cs_n[i]}, {31'h0, exp_cs(i)});
    end
  end

  task automatic access(input int sel, input bit we, input logic [31:0] addr,
                        input logic [1:0] size, input logic [31:0] wd,
                        input string tag, input bit poke);
    logic [31:0] c = ctl[sel];
    logic [1:0] m = c[1:0];
    logic [7:0] op = (m == 2'd0) ? 8'h03 : c[23:16];
    int nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    bit rej = we ? (!wr_en[sel] || m < 2) : (m == 2'd2);
    bit zero = (m == 2'd1 || m == 2'd2) && op == 8'h00;
    logic [31:0] exp_rd = '0;
    int cnt = 0;
    cur_tag = tag;
    exp_tx.delete();
    rx_log.delete();
    if (!rej) begin
      if (m != 2'd3) begin
        exp_tx.push_back(op);
        for (int b = (addr4[sel] ? 3 : 2); b >= 0; b--) exp_tx.push_back(8'((addr >> (8*b)) & 32'hff));
        if (m == 2'd1) begin
          int nd = {c[14], c[7:6]} * 8;
          if (c[28]) nd = nd / 2;
          for (int d = 0; d < nd; d++) exp_tx.push_back(dummy_byte);
        end
      end
      for (int i = 0; i < nb; i++) exp_tx.push_back(we ? 8'((wd >> (8*i)) & 32'hff) : 8'h00);
    end
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_sel = 1'(sel); bus_addr = addr;
    bus_size = size; bus_wdata = wd;
    active = 1'b1; cur_sel = sel;
    @(negedge clk);
    bus_req = 1'b0;
    while (!bus_ready && cnt < 3000) begin
      if (poke && cnt == 5) begin
        bus_req = 1'b1; bus_sel = 1'(1 - sel); bus_we = 1'b0;
      end else begin
        bus_req = 1'b0; bus_sel = 1'(sel); bus_we = we;
      end
      @(negedge clk);
      cnt++;
    end
    bus_req = 1'b0;
    chk(bus_ready, tag, "completion", {31'h0, bus_ready}, 32'h1);
    chk(bus_err == (rej || zero), tag, "error flag", {31'h0, bus_err}, {31'h0, rej || zero});
    if (rej) chk(cnt == 0, "R10", "reject latency", cnt, 0);
    if (!we && !rej) begin
      for (int i = 0; i < nb; i++)
        exp_rd[8*i +: 8] = rx_log[rx_log.size() - nb + i];
      chk(bus_rdata == exp_rd, tag, "read data R7", bus_rdata, exp_rd);
    end
    chk(exp_tx.size() == 0, tag, "bytes left unsent", exp_tx.size(), 0);
    active = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!bus_ready && !sh_start, "R12", "quiet after done", {30'h0, bus_ready, sh_start}, 32'h0);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    ctl[0] = mk_ctl(2'd0, 8'hab, 1'b0, 2'd3, 1'b0, 1'b1);
    ctl[1] = mk_ctl(2'd0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1);
    addr4 = 2'b10;
    repeat (4) @(negedge clk);
    chk(cs_n == 2'b11, "R6", "reset cs_n", {30'h0, cs_n}, 32'h3);
    chk(!bus_ready && !sh_start, "R12", "reset outputs", {30'h0, bus_ready, sh_start}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: read mode forces 0x03, ignores dummy bits, 3-byte address
    access(0, 1'b0, 32'h7f123456, 2'd2, 32'h0, "R1 R5", 1'b0);

    // R3 R4 R5: fast read, 4-byte address, 40 dummies
    ctl[1] = mk_ctl(2'd1, 8'h0c, 1'b1, 2'd1, 1'b0, 1'b1);
    dummy_byte = 8'ha5;
    access(1, 1'b0, 32'h89abcdef, 2'd1, 32'h0, "R3 R4 R5", 1'b0);

    // R3: dual flag halves 16 dummies to 8
    ctl[0] = mk_ctl(2'd1, 8'h3b, 1'b0, 2'd2, 1'b1, 1'b1);
    dummy_byte = 8'h5a;
    access(0, 1'b0, 32'h00fedcba, 2'd0, 32'h0, "R3 R4", 1'b0);

    // R7 R11: write mode, four data bytes little-endian
    wr_en = 2'b01;
    ctl[0] = mk_ctl(2'd2, 8'h02, 1'b1, 2'd3, 1'b0, 1'b1);
    access(0, 1'b1, 32'h00010203, 2'd2, 32'hdeadbeef, "R7 R11", 1'b0);
    access(0, 1'b1, 32'h00000040, 2'd0, 32'h000000c3, "R11", 1'b0);

    // R9: write without permission
    ctl[1] = mk_ctl(2'd2, 8'h02, 1'b0, 2'd0, 1'b0, 1'b1);
    access(1, 1'b1, 32'h11223344, 2'd1, 32'h0000abcd, "R9", 1'b0);

    // R10: write in read modes, read in write mode
    access(0, 1'b0, 32'h00000100, 2'd0, 32'h0, "R10", 1'b0);
    ctl[0] = mk_ctl(2'd0, 8'h03, 1'b0, 2'd0, 1'b0, 1'b1);
    access(0, 1'b1, 32'h00000100, 2'd0, 32'h55, "R10", 1'b0);
    ctl[0] = mk_ctl(2'd1, 8'h0b, 1'b0, 2'd1, 1'b0, 1'b1);
    access(0, 1'b1, 32'h00000100, 2'd0, 32'h55, "R10", 1'b0);

    // R2: zero opcode in fast-read mode still runs, flags error
    ctl[0] = mk_ctl(2'd1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1);
    access(0, 1'b0, 32'h00abcdef, 2'd3, 32'h0, "R2 R11", 1'b0);

    // R8: pass-through on cs1 with select held low by software
    wr_en = 2'b11;
    @(negedge clk);
    ctl[1] = mk_ctl(2'd3, 8'h00, 1'b0, 2'd3, 1'b1, 1'b0);
    access(1, 1'b1, 32'h00000000, 2'd0, 32'h0000009f, "R8", 1'b0);
    access(1, 1'b0, 32'h00000000, 2'd1, 32'h0, "R8 R7", 1'b0);

    // R12: stray request during a running read on cs0 is ignored
    ctl[0] = mk_ctl(2'd0, 8'h77, 1'b0, 2'd0, 1'b0, 1'b1);
    access(0, 1'b0, 32'h00c0ffee, 2'd2, 32'h0, "R12", 1'b1);

    @(negedge clk);
    ctl[1] = mk_ctl(2'd3, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk(cs_n[1] == 1'b1, "R8", "software release", {31'h0, cs_n[1]}, 32'h1);
    report();
  end
endmodule